// File: doc/BRIEF.md
# Power-Management Control/Status Register

This block holds the 16-bit power-management control and status word of a bus-attached peripheral function, and drives the function's wake-event output from it. Configuration software reaches it through a simple write port (address, byte enables, write data) and a combinational read port. The word carries a wake-event status flag, a wake enable and a two-bit device power state. A read-only extension word sits at the next word address.

A wake request from the function sets the status flag whether or not signalling is enabled. The wake output is the registered AND of status and enable. Software clears the flag by writing one to it. When software moves the power state from D3 to D0, the block emits a one-cycle pulse. The surrounding logic uses that pulse to raise the function-level reset. The register contents live in the global-reset domain so that this reset cannot disturb them. A parameter selects whether the wake enable survives the function reset (wake from the unpowered state supported) or is cleared by it.

Top module: `pm_csr_top`

## Requirements
- R1: After global reset, the word at the control address (48h) reads 0000h, the extension word (4Ah) reads 0000h, and pwr_state, pme_out and d3_exit_pulse are 0.
- R2: A cycle with wake_req high sets bit 15 (wake status) at the next clock edge, whatever the value of bit 8 (wake enable).
- R3: A write to 48h with cfg_be[1] set and data bit 15 at 1 clears bit 15, and a write with data bit 15 at 0 leaves it unchanged. When wake_req is high in the same cycle as such a clear, the flag stays set.
- R4: Bit 8 is read/write through the high byte. pme_out is 1 exactly when bits 15 and 8 are both 1, and it changes at the same clock edge as those bits.
- R5: Bits 1:0 hold the power state (00=D0, 01=D1, 10=D2, 11=D3). They take data bits 1:0 on a write to 48h with cfg_be[0] set, appear on pwr_state, and change in no other way except through global reset.
- R6: The function reset (frst_n low) leaves bits 15 and 1:0 unchanged. With D3COLD_WAKE=1 it also leaves bit 8 unchanged. With D3COLD_WAKE=0 it clears bit 8, and with it pme_out.
- R7: d3_exit_pulse is high for exactly one cycle after a write that changes bits 1:0 from 11 to 00, and for no other transition, including 00 to 00 and 10 to 00.
- R8: Byte enables are honoured: cfg_be[0] alone touches only bits 7:0, cfg_be[1] alone touches only bits 15:8, and a write with no byte enable or to any other address changes nothing.
- R9: Bits 14:9 and 7:2 of the control word always read 0. The extension word at 4Ah always reads 0000h and writes to it have no effect. Any other address reads 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| grst_n | input | 1 | Global reset, asynchronous active low, released synchronously |
| frst_n | input | 1 | Function-level reset, asynchronous active low |
| cfg_wr | input | 1 | Write strobe for one cycle |
| cfg_addr | input | ADDR_W | Configuration byte address, word aligned |
| cfg_be | input | 2 | Byte enables: bit 0 for data 7:0, bit 1 for data 15:8 |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for cfg_addr, combinational |
| wake_req | input | 1 | Wake event request from the function |
| pwr_state | output | 2 | Current power state |
| pme_out | output | 1 | Wake event output, active high, registered |
| d3_exit_pulse | output | 1 | One-cycle request for the function reset on a D3 to D0 write |

## Verification
Two cases are the hardest to reach from the ports. The first is a wake request that lands in the very cycle software writes one to the status bit. The bench raises wake_req inside the write task on the same edge as the clearing write. The second is the function-reset behaviour of the enable under both settings of the support parameter. A second instance built with D3COLD_WAKE=0 shares every stimulus with the default one. The function reset is applied with status, enable and a non-zero power state all set, and both read words are then compared against their own expected values.

// File: rtl/pm_csr_pkg.sv
package pm_csr_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned STS_BIT  = 15;
  localparam int unsigned EN_BIT   = 8;
  localparam int unsigned STATE_W  = 2;
  localparam logic [WORD_W-1:0] RSVD_MASK = 16'h7EFC;

  typedef enum logic [STATE_W-1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;
endpackage

// File: rtl/pm_csr_decode.sv
module pm_csr_decode #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CSR_OFFS = 8'h48,
  parameter logic [ADDR_W-1:0] EXT_OFFS = 8'h4A
) (
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_be,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              sel_csr,
  output logic              sel_ext
);
  always_comb begin
    sel_csr = (cfg_addr == CSR_OFFS);
    sel_ext = (cfg_addr == EXT_OFFS);
    wr_lo   = cfg_wr && sel_csr && cfg_be[0];
    wr_hi   = cfg_wr && sel_csr && cfg_be[1];
  end
endmodule

// File: rtl/pm_csr_regs.sv
module pm_csr_regs
  import pm_csr_pkg::*;
#(
  parameter bit D3COLD_WAKE = 1'b1
) (
  input  logic         clk,
  input  logic         grst_n,
  input  logic         frst_n,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [STATE_W-1:0] wd_state,
  input  logic         wd_en,
  input  logic         wd_sts,
  input  logic         wake_req,
  output logic         en_rst_n,
  output logic         sts_q,
  output logic         en_q,
  output pstate_e      state_q,
  output logic         sts_d,
  output logic         en_d,
  output pstate_e      state_d
);
  logic sts_ce, en_ce, state_ce;

  // Reset domain of the enable bit is a build-time choice.
  generate
    if (D3COLD_WAKE) begin : g_en_sticky
      assign en_rst_n = grst_n;
    end else begin : g_en_func
      assign en_rst_n = grst_n & frst_n;
    end
  endgenerate

  // Next-state logic. A new wake event takes priority over a clear.
  always_comb begin
    sts_d = sts_q;
    if (wr_hi && wd_sts) sts_d = 1'b0;
    if (wake_req)        sts_d = 1'b1;
    en_d    = wr_hi ? wd_en : en_q;
    state_d = wr_lo ? pstate_e'(wd_state) : state_q;
    sts_ce   = wake_req | (wr_hi & wd_sts);
    en_ce    = wr_hi;
    state_ce = wr_lo;
  end

  always_ff @(posedge clk or negedge grst_n) begin
    if (!grst_n) begin
      sts_q   <= 1'b0;
      state_q <= PS_D0;
    end else begin
      if (sts_ce)   sts_q   <= sts_d;
      if (state_ce) state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge en_rst_n) begin
    if (!en_rst_n) begin
      en_q <= 1'b0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/pm_csr_wake.sv
module pm_csr_wake
  import pm_csr_pkg::*;
(
  input  logic    clk,
  input  logic    grst_n,
  input  logic    en_rst_n,
  input  logic    sts_d,
  input  logic    en_d,
  input  pstate_e state_q,
  input  pstate_e state_d,
  output logic    pme_q,
  output logic    pulse_q
);
  logic pme_nxt, pme_ce, pulse_nxt, pulse_ce;

  always_comb begin
    pme_nxt   = sts_d & en_d;
    pme_ce    = (pme_nxt != pme_q);
    pulse_nxt = (state_q == PS_D3) && (state_d == PS_D0);
    pulse_ce  = (pulse_nxt != pulse_q);
  end

  always_ff @(posedge clk or negedge en_rst_n) begin
    if (!en_rst_n) begin
      pme_q <= 1'b0;
    end else if (pme_ce) begin
      pme_q <= pme_nxt;
    end
  end

  always_ff @(posedge clk or negedge grst_n) begin
    if (!grst_n) begin
      pulse_q <= 1'b0;
    end else if (pulse_ce) begin
      pulse_q <= pulse_nxt;
    end
  end
endmodule

// File: rtl/pm_csr_rdmux.sv
module pm_csr_rdmux
  import pm_csr_pkg::*;
(
  input  logic              sel_csr,
  input  logic              sel_ext,
  input  logic              sts_q,
  input  logic              en_q,
  input  pstate_e           state_q,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] csr_word;

  always_comb begin
    csr_word = '0;
    csr_word[STS_BIT] = sts_q;
    csr_word[EN_BIT]  = en_q;
    csr_word[STATE_W-1:0] = state_q;
    // The extension word is hard zero; any unknown address reads zero.
    if (sel_csr)      rdata = csr_word;
    else if (sel_ext) rdata = '0;
    else              rdata = '0;
  end
endmodule

// File: rtl/pm_csr_top.sv
module pm_csr_top
  import pm_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CSR_OFFS = 8'h48,
  parameter logic [ADDR_W-1:0] EXT_OFFS = 8'h4A,
  parameter bit D3COLD_WAKE = 1'b1
) (
  input  logic              clk,
  input  logic              grst_n,
  input  logic              frst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_be,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              wake_req,
  output logic [1:0]        pwr_state,
  output logic              pme_out,
  output logic              d3_exit_pulse
);
  logic    csr_wr_lo, csr_wr_hi, sel_csr, sel_ext;
  logic    en_rst_n;
  logic    csr_sts, csr_en, sts_d, en_d;
  pstate_e csr_state, state_d;

  pm_csr_decode #(
    .ADDR_W(ADDR_W), .CSR_OFFS(CSR_OFFS), .EXT_OFFS(EXT_OFFS)
  ) u_decode (
    .cfg_wr  (cfg_wr),
    .cfg_addr(cfg_addr),
    .cfg_be  (cfg_be),
    .wr_lo   (csr_wr_lo),
    .wr_hi   (csr_wr_hi),
    .sel_csr (sel_csr),
    .sel_ext (sel_ext)
  );

  pm_csr_regs #(.D3COLD_WAKE(D3COLD_WAKE)) u_regs (
    .clk     (clk),
    .grst_n  (grst_n),
    .frst_n  (frst_n),
    .wr_lo   (csr_wr_lo),
    .wr_hi   (csr_wr_hi),
    .wd_state(cfg_wdata[STATE_W-1:0]),
    .wd_en   (cfg_wdata[EN_BIT]),
    .wd_sts  (cfg_wdata[STS_BIT]),
    .wake_req(wake_req),
    .en_rst_n(en_rst_n),
    .sts_q   (csr_sts),
    .en_q    (csr_en),
    .state_q (csr_state),
    .sts_d   (sts_d),
    .en_d    (en_d),
    .state_d (state_d)
  );

  pm_csr_wake u_wake (
    .clk     (clk),
    .grst_n  (grst_n),
    .en_rst_n(en_rst_n),
    .sts_d   (sts_d),
    .en_d    (en_d),
    .state_q (csr_state),
    .state_d (state_d),
    .pme_q   (pme_out),
    .pulse_q (d3_exit_pulse)
  );

  pm_csr_rdmux u_rdmux (
    .sel_csr(sel_csr),
    .sel_ext(sel_ext),
    .sts_q  (csr_sts),
    .en_q   (csr_en),
    .state_q(csr_state),
    .rdata  (cfg_rdata)
  );

  assign pwr_state = csr_state;
endmodule

// File: rtl/pm_csr_chk.sv
module pm_csr_chk (
  input logic        clk,
  input logic        grst_n,
  input logic        wake_req,
  input logic        csr_wr_lo,
  input logic        csr_sts,
  input logic        csr_en,
  input logic [1:0]  csr_state,
  input logic        pme_out,
  input logic        d3_exit_pulse,
  input logic [15:0] cfg_rdata
);
  // R2: a wake request always lands in the status flag
  p_status_set_r2: assert property (@(posedge clk) disable iff (!grst_n)
    wake_req |=> csr_sts);

  // R4: the wake output never rises without the enable
  p_pme_enable_r4: assert property (@(posedge clk) disable iff (!grst_n)
    pme_out |-> (csr_en && csr_sts));

  // R5: power state moves only on a low-byte write
  p_state_stable_r5: assert property (@(posedge clk) disable iff (!grst_n)
    !csr_wr_lo |=> $stable(csr_state));

  // R7: the exit pulse follows a D3 to D0 change and lasts one cycle
  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!grst_n)
    d3_exit_pulse |-> ($past(csr_state) == 2'b11 && csr_state == 2'b00));

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!grst_n)
    d3_exit_pulse |=> !d3_exit_pulse);

  // R9: reserved fields read zero
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!grst_n)
    (cfg_rdata & 16'h7EFC) == 16'h0000);
endmodule

bind pm_csr_top pm_csr_chk u_chk (.*);

// File: tb/test_pm_csr_top.sv
module test_pm_csr_top;
  logic        clk = 1'b0;
  logic        grst_n, frst_n, cfg_wr, wake_req;
  logic [7:0]  cfg_addr;
  logic [1:0]  cfg_be;
  logic [15:0] cfg_wdata;
  logic [15:0] rdata, rdata_nc;
  logic [1:0]  pstate, pstate_nc;
  logic        pme, pme_nc, pulse, pulse_nc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model
  logic       m_sts, m_en, m_en_nc;
  logic [1:0] m_state;
  logic       m_pulse;

  always #2 clk = ~clk;

  pm_csr_top i_pm_csr_top (
    .clk(clk), .grst_n(grst_n), .frst_n(frst_n), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata), .wake_req(wake_req), .pwr_state(pstate),
    .pme_out(pme), .d3_exit_pulse(pulse)
  );

  pm_csr_top #(.D3COLD_WAKE(1'b0)) i_pm_csr_top_nc (
    .clk(clk), .grst_n(grst_n), .frst_n(frst_n), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata_nc), .wake_req(wake_req), .pwr_state(pstate_nc),
    .pme_out(pme_nc), .d3_exit_pulse(pulse_nc)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input logic en);
    return {m_sts, 6'b0, en, 6'b0, m_state};
  endfunction

  task automatic outs(input string tag);
    chk({tag, " state"}, {14'b0, pstate}, {14'b0, m_state});
    chk({tag, " state_nc"}, {14'b0, pstate_nc}, {14'b0, m_state});
    chk({tag, " pme R4"}, {15'b0, pme}, {15'b0, m_sts & m_en});
    chk({tag, " pme_nc R4"}, {15'b0, pme_nc}, {15'b0, m_sts & m_en_nc});
    chk({tag, " pulse R7"}, {14'b0, pulse, pulse_nc}, {14'b0, m_pulse, m_pulse});
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    cfg_addr = a;
    #1;
    if (a == 8'h48) begin
      chk({tag, " rd"}, rdata, word(m_en));
      chk({tag, " rd_nc"}, rdata_nc, word(m_en_nc));
    end else begin
      chk({tag, " rd R9"}, rdata, 16'h0000);
      chk({tag, " rd_nc R9"}, rdata_nc, 16'h0000);
    end
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [1:0] be,
                    input logic [15:0] d, input logic wk);
    logic [1:0] old;
    @(negedge clk);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1; wake_req = wk;
    old = m_state;
    m_pulse = 1'b0;
    if (a == 8'h48) begin
      if (be[0]) begin
        m_state = d[1:0];
        m_pulse = (old == 2'b11) && (d[1:0] == 2'b00);
      end
      if (be[1]) begin
        if (d[15]) m_sts = 1'b0;
        m_en = d[8];
        m_en_nc = d[8];
      end
    end
    if (wk) m_sts = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; wake_req = 1'b0;
    outs(tag);
    m_pulse = 1'b0;
  endtask

  task automatic wake1();
    @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    m_sts = 1'b1;
  endtask

  function automatic logic [15:0] pat(input int p);
    case (p)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8103;
      default: return 16'h7EFE;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    grst_n = 1'b0; frst_n = 1'b1; cfg_wr = 1'b0; wake_req = 1'b0;
    cfg_addr = 8'h48; cfg_be = 2'b00; cfg_wdata = 16'h0000;
    m_sts = 0; m_en = 0; m_en_nc = 0; m_state = 0; m_pulse = 0;
    repeat (3) @(negedge clk);
    grst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    outs("R1 reset");
    rd("R1 csr", 8'h48);
    rd("R1 ext", 8'h4A);

    // R5 / R7: every pair of power-state writes
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        wr("R5 from", 8'h48, 2'b01, 16'(s), 1'b0);
        wr("R7 to", 8'h48, 2'b01, 16'(t), 1'b0);
        rd("R5 word", 8'h48);
        @(negedge clk);
        chk("R7 single cycle", {15'b0, pulse}, 16'h0000);
      end
    end

    // R2: wake with enable off
    wr("R2 en off", 8'h48, 2'b10, 16'h0000, 1'b0);
    wake1();
    outs("R2 set");
    rd("R2 set word", 8'h48);
    // R4: enabling drives the output
    wr("R4 en on", 8'h48, 2'b10, 16'h0100, 1'b0);
    rd("R4 word", 8'h48);
    // R3: zero to status has no effect, one clears, set beats clear
    wr("R3 write0", 8'h48, 2'b10, 16'h0100, 1'b0);
    wr("R3 write1", 8'h48, 2'b10, 16'h8100, 1'b0);
    rd("R3 cleared", 8'h48);
    wake1();
    outs("R3 reset flag");
    wr("R3 set wins", 8'h48, 2'b10, 16'h8100, 1'b1);
    rd("R3 set wins word", 8'h48);

    // R8: byte-enable sweep with status armed before each write
    for (int be = 0; be < 4; be++) begin
      for (int p = 0; p < 4; p++) begin
        wake1();
        wr("R8 be", 8'h48, 2'(be), pat(p), 1'b0);
        rd("R8 word", 8'h48);
      end
    end

    // R9: extension and other addresses ignore writes
    wake1();
    wr("R8 seed", 8'h48, 2'b11, 16'h0102, 1'b0);
    wr("R9 ext wr", 8'h4A, 2'b11, 16'hFFFF, 1'b0);
    rd("R9 ext rd", 8'h4A);
    rd("R9 csr kept", 8'h48);
    wr("R8 other addr", 8'h40, 2'b11, 16'h8003, 1'b0);
    rd("R8 other kept", 8'h48);
    rd("R9 other rd", 8'h4C);

    // R6: function reset with status, enable and state D2 all set
    wake1();
    wr("R6 seed", 8'h48, 2'b11, 16'h0102, 1'b0);
    @(negedge clk);
    frst_n = 1'b0;
    m_en_nc = 1'b0;
    @(negedge clk);
    outs("R6 during");
    @(negedge clk);
    frst_n = 1'b1;
    @(negedge clk);
    outs("R6 after");
    rd("R6 word", 8'h48);

    // R1: global reset mid-run clears everything
    @(negedge clk);
    grst_n = 1'b0;
    m_sts = 0; m_en = 0; m_en_nc = 0; m_state = 0;
    @(negedge clk);
    outs("R1 mid reset");
    rd("R1 mid word", 8'h48);
    grst_n = 1'b1;
    @(negedge clk);
    rd("R1 after word", 8'h48);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule